// File: doc/BRIEF.md
# H-Bridge Command Decoder with Sticky Fault Latch

This block is the control logic of a brushed DC motor H-bridge. Two direction inputs each steer one leg of the bridge: a low level turns that leg's high-side switch on, and a high level turns the high side off and makes the leg's low-side switch eligible to conduct. A separate drive-enable input, combined with a chopping-allow input from the current regulator, gates both low-side switches. When both direction inputs are high and the enable is high, both low sides conduct and the motor is braked. When both are low, both high sides conduct whatever the enable does. When a leg changes direction, the block inserts its own off phase, so the host needs no dead-time sequencing.

Three digital fault flags come from analog comparators: output short, overcurrent and overtemperature. Any accepted flag forces all four gate commands off and pulls the active-low fault output low. This state is sticky. Only the power-on reset or the supply-undervoltage lockout clears it. The short flag is ignored during a configurable blanking window after any change of the gate commands, which masks switching transients. Two supply comparator flags give the lockout its hysteresis: the lower threshold trips it and the upper threshold releases it. While locked out, the whole block is held in its reset state.

Top module: `hb_cmd_decoder`

## Requirements
- R1: With direction input bit i at 0 and the leg settled, leg i's high-side command is 1 and its low-side command is 0, one clock after sampling.
- R2: With direction bit i at 1 and the leg settled, leg i's high side is 0 and its low side equals drive_en AND chop_allow sampled on the previous edge. With drive_en low, that leg floats (both commands 0).
- R3: A low-side command is only ever 1 in the cycle after drive_en and chop_allow were both sampled high. A one-cycle enable pulse produces a one-cycle low-side pulse.
- R4: dir_sel=2'b11 with enable gives both low sides on (brake). dir_sel=2'b00 gives both high sides on, with enable high or low.
- R5: The high-side and low-side commands of one leg are never 1 together.
- R6: When direction bit i changes, both commands of leg i are 0 for exactly DEAD_CYC cycles, starting at the sampling edge. The new state appears on the next edge. A high-side command is never followed directly by that leg's low-side command, or the reverse.
- R7: An overcurrent or overtemperature flag sampled high, outside lockout, sets all gate commands to 0 and fault_n to 0 on that edge.
- R8: Once fault_n is 0 it stays 0, and the gates stay off, after the flags drop. Only por_n low or the lockout clears it.
- R9: The short flag is ignored while the gate commands have changed within the last SC_BLANK cycles. Once they have been stable longer, it trips the fault latch as in R7.
- R10: vdd_trip_ok sampled low enters lockout. From the following edge on, all gates are 0 and fault_n is 1. Lockout is left only when vdd_rel_ok is sampled high, so trip_ok high with rel_ok low keeps it. After leaving, both legs restart from the high-sides-off state with a dead-time phase where needed.
- R11: During and right after por_n low, all gate commands are 0 and fault_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| vdd_trip_ok | input | 1 | Supply above the lower (trip) threshold |
| vdd_rel_ok | input | 1 | Supply above the upper (release) threshold |
| dir_sel | input | 2 | Direction bit per leg; 0 = high side, 1 = low side eligible |
| drive_en | input | 1 | Low-side enable, may be pulse-width modulated |
| chop_allow | input | 1 | Current-regulator gating of both low sides |
| flt_short | input | 1 | Output short comparator flag |
| flt_ocur | input | 1 | Overcurrent comparator flag |
| flt_otemp | input | 1 | Overtemperature comparator flag |
| hs_on | output | 2 | High-side gate command per leg |
| ls_on | output | 2 | Low-side gate command per leg |
| fault_n | output | 1 | Active-low sticky fault indication |

## Verification
The properties assume that every input is already synchronous to clk and that the two supply flags are consistent, with rel_ok never high while trip_ok is low. The stimulus keeps to this by changing inputs only on the falling clock edge and by driving the supply flags as a pair that steps through trip, partial recovery and full release. The properties do not model the short-flag blanking window, so short-flag behaviour is covered by directed stimulus alone: one short pulse inside the window and one after a long stable stretch.

// File: rtl/hb_pkg.sv
package hb_pkg;
   localparam int LEGS = 2;

   typedef struct packed {
      logic hs;
      logic ls;
   } leg_cmd_t;
endpackage

// File: rtl/hb_uvlo.sv
module hb_uvlo (
   input  logic clk,
   input  logic por_n,
   input  logic trip_ok,
   input  logic rel_ok,
   output logic lock_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         lock_q <= 1'b1;
      else if (!trip_ok)
         lock_q <= 1'b1;
      else if (rel_ok)
         lock_q <= 1'b0;
   end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
   import hb_pkg::*;
#(
   parameter int DEAD_CYC = 4
) (
   input  logic     clk,
   input  logic     por_n,
   input  logic     hold,
   input  logic     kill,
   input  logic     dir,
   input  logic     low_ok,
   output leg_cmd_t cmd
);
   localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

   logic cur_q;
   logic change;
   logic busy;

   assign change = (dir != cur_q);

   generate
      if (DEAD_CYC > 1) begin : g_dead_cnt
         logic [DW-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               cnt_q <= '0;
            else if (hold)
               cnt_q <= '0;
            else if (change)
               cnt_q <= DW'(DEAD_CYC - 1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
      end else begin : g_dead_one
         assign busy = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cur_q <= 1'b1;
         cmd   <= '0;
      end else if (hold) begin
         cur_q <= 1'b1;
         cmd   <= '0;
      end else begin
         if (change) begin
            cur_q <= dir;
            cmd   <= '0;
         end else if (busy) begin
            cmd   <= '0;
         end else begin
            cmd.hs <= ~cur_q;
            cmd.ls <= cur_q & low_ok;
         end
         if (kill)
            cmd <= '0;
      end
   end
endmodule

// File: rtl/hb_fault.sv
module hb_fault #(
   parameter int GW       = 4,
   parameter int SC_BLANK = 8
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          hold,
   input  logic          f_short,
   input  logic          f_ocur,
   input  logic          f_otemp,
   input  logic [GW-1:0] gates,
   output logic          trip_now,
   output logic          latched
);
   localparam int BW = $clog2(SC_BLANK + 1) + 1;

   logic short_ok;

   generate
      if (SC_BLANK > 0) begin : g_blank
         logic [GW-1:0] gates_d1;
         logic [BW-1:0] stab_q;
         logic          chg;
         assign chg = (gates != gates_d1);
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               gates_d1 <= '0;
               stab_q   <= '0;
            end else if (hold) begin
               gates_d1 <= '0;
               stab_q   <= '0;
            end else begin
               gates_d1 <= gates;
               if (chg)
                  stab_q <= '0;
               else if (stab_q < BW'(SC_BLANK))
                  stab_q <= stab_q + 1'b1;
            end
         end
         assign short_ok = !chg && (stab_q >= BW'(SC_BLANK));
      end else begin : g_noblank
         assign short_ok = 1'b1;
      end
   endgenerate

   assign trip_now = !hold && (f_ocur || f_otemp || (f_short && short_ok));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         latched <= 1'b0;
      else if (hold)
         latched <= 1'b0;
      else if (trip_now)
         latched <= 1'b1;
   end
endmodule

// File: rtl/hb_cmd_decoder.sv
module hb_cmd_decoder
   import hb_pkg::*;
#(
   parameter int DEAD_CYC = 4,
   parameter int SC_BLANK = 8
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            vdd_trip_ok,
   input  logic            vdd_rel_ok,
   input  logic [LEGS-1:0] dir_sel,
   input  logic            drive_en,
   input  logic            chop_allow,
   input  logic            flt_short,
   input  logic            flt_ocur,
   input  logic            flt_otemp,
   output logic [LEGS-1:0] hs_on,
   output logic [LEGS-1:0] ls_on,
   output logic            fault_n
);
   localparam int GW = 2 * LEGS;

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
      if (SC_BLANK < 0) begin : g_bad_blank
         $error("SC_BLANK must not be negative");
      end
   endgenerate

   logic     lock_q;
   logic     trip_now;
   logic     latched;
   logic     kill;
   logic     low_ok;
   leg_cmd_t cmd [LEGS];

   assign low_ok = drive_en & chop_allow;
   assign kill   = trip_now | latched;

   hb_uvlo u_uvlo (
      .clk     (clk),
      .por_n   (por_n),
      .trip_ok (vdd_trip_ok),
      .rel_ok  (vdd_rel_ok),
      .lock_q  (lock_q)
   );

   generate
      for (genvar i = 0; i < LEGS; i++) begin : g_leg
         hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk    (clk),
            .por_n  (por_n),
            .hold   (lock_q),
            .kill   (kill),
            .dir    (dir_sel[i]),
            .low_ok (low_ok),
            .cmd    (cmd[i])
         );
         assign hs_on[i] = cmd[i].hs;
         assign ls_on[i] = cmd[i].ls;
      end
   endgenerate

   hb_fault #(.GW(GW), .SC_BLANK(SC_BLANK)) u_fault (
      .clk      (clk),
      .por_n    (por_n),
      .hold     (lock_q),
      .f_short  (flt_short),
      .f_ocur   (flt_ocur),
      .f_otemp  (flt_otemp),
      .gates    ({hs_on, ls_on}),
      .trip_now (trip_now),
      .latched  (latched)
   );

   assign fault_n = ~latched;
endmodule

// File: rtl/hb_cmd_chk.sv
module hb_cmd_chk #(
   parameter int LEGS = 2
) (
   input logic            clk,
   input logic            por_n,
   input logic            drive_en,
   input logic            chop_allow,
   input logic            flt_ocur,
   input logic            flt_otemp,
   input logic            vdd_trip_ok,
   input logic            lock_q,
   input logic [LEGS-1:0] hs_on,
   input logic [LEGS-1:0] ls_on,
   input logic            fault_n
);
   generate
      for (genvar i = 0; i < LEGS; i++) begin : g_leg_chk
         assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!por_n)
            !(hs_on[i] && ls_on[i]));
         assert_low_needs_enable_R3: assert property (@(posedge clk) disable iff (!por_n)
            ls_on[i] |-> $past(drive_en && chop_allow));
         assert_dead_hs_to_ls_R6: assert property (@(posedge clk) disable iff (!por_n)
            hs_on[i] |=> !ls_on[i]);
         assert_dead_ls_to_hs_R6: assert property (@(posedge clk) disable iff (!por_n)
            ls_on[i] |=> !hs_on[i]);
      end
   endgenerate

   assert_fault_trip_R7: assert property (@(posedge clk) disable iff (!por_n)
      ((flt_ocur || flt_otemp) && !lock_q) |=> (!fault_n && hs_on == '0 && ls_on == '0));

   assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!fault_n && !lock_q && vdd_trip_ok) |=> (!fault_n && hs_on == '0 && ls_on == '0));

   assert_lockout_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> (fault_n && hs_on == '0 && ls_on == '0));
endmodule

bind hb_cmd_decoder hb_cmd_chk #(.LEGS(hb_pkg::LEGS)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .drive_en    (drive_en),
   .chop_allow  (chop_allow),
   .flt_ocur    (flt_ocur),
   .flt_otemp   (flt_otemp),
   .vdd_trip_ok (vdd_trip_ok),
   .lock_q      (lock_q),
   .hs_on       (hs_on),
   .ls_on       (ls_on),
   .fault_n     (fault_n)
);

// File: tb/hb_cmd_decoder_test.sv
`timescale 1ns/1ps
module hb_cmd_decoder_test;
   localparam int DEAD = 4;
   localparam int BLANK = 8;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       trip_ok = 1'b1;
   logic       rel_ok = 1'b1;
   logic [1:0] dir = 2'b11;
   logic       en = 1'b0;
   logic       allow = 1'b1;
   logic       f_sc = 1'b0;
   logic       f_oc = 1'b0;
   logic       f_ot = 1'b0;
   logic [1:0] hs;
   logic [1:0] ls;
   logic       fn;

   typedef struct {
      logic [1:0] hs;
      logic [1:0] ls;
      logic       fn;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #4 clk = ~clk;

   hb_cmd_decoder #(.DEAD_CYC(DEAD), .SC_BLANK(BLANK)) uut (
      .clk         (clk),
      .por_n       (por_n),
      .vdd_trip_ok (trip_ok),
      .vdd_rel_ok  (rel_ok),
      .dir_sel     (dir),
      .drive_en    (en),
      .chop_allow  (allow),
      .flt_short   (f_sc),
      .flt_ocur    (f_oc),
      .flt_otemp   (f_ot),
      .hs_on       (hs),
      .ls_on       (ls),
      .fault_n     (fn)
   );

   // monitor: compares 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (hs !== e.hs || ls !== e.ls || fn !== e.fn) begin
            n_bad++;
            $display("FAIL %s: got hs=%b ls=%b fault_n=%b, expected hs=%b ls=%b fault_n=%b",
                     e.tag, hs, ls, fn, e.hs, e.ls, e.fn);
         end
      end
   end

   // driver: inputs already set by caller just after a falling edge
   task automatic st(input string tag, input logic [1:0] eh, input logic [1:0] el,
                     input logic ef);
      exp_t e;
      e.hs = eh; e.ls = el; e.fn = ef; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      // R11: reset state
      st("R11 reset", 2'b00, 2'b00, 1'b1);
      st("R11 reset held", 2'b00, 2'b00, 1'b1);
      por_n = 1'b1;
      st("R11 first edge after reset", 2'b00, 2'b00, 1'b1);
      st("R2 enable low floats", 2'b00, 2'b00, 1'b1);
      en = 1'b1;
      st("R4 brake both low sides", 2'b00, 2'b11, 1'b1);
      en = 1'b0;
      st("R3 enable low drops low sides", 2'b00, 2'b00, 1'b1);
      en = 1'b1;
      st("R3 one-cycle pulse high", 2'b00, 2'b11, 1'b1);
      en = 1'b0;
      st("R3 one-cycle pulse ends", 2'b00, 2'b00, 1'b1);
      en = 1'b1; allow = 1'b0;
      st("R3 chop gating blocks low sides", 2'b00, 2'b00, 1'b1);
      allow = 1'b1;
      st("R2 low sides with enable", 2'b00, 2'b11, 1'b1);
      // leg0 turns to high side
      dir = 2'b10;
      for (int k = 0; k < DEAD; k++) st("R6 leg0 dead time", 2'b00, 2'b10, 1'b1);
      st("R1 leg0 high side after dead time", 2'b01, 2'b10, 1'b1);
      en = 1'b0;
      st("R2 leg1 floats with enable low", 2'b01, 2'b00, 1'b1);
      dir = 2'b00;
      for (int k = 0; k < DEAD; k++) st("R6 leg1 dead time", 2'b01, 2'b00, 1'b1);
      st("R4 both high sides", 2'b11, 2'b00, 1'b1);
      en = 1'b1;
      st("R4 both high sides regardless of enable", 2'b11, 2'b00, 1'b1);
      // lockout with hysteresis
      trip_ok = 1'b0; rel_ok = 1'b0;
      st("R10 trip sampled, outputs still live", 2'b11, 2'b00, 1'b1);
      trip_ok = 1'b1;
      st("R10 lockout clears gates", 2'b00, 2'b00, 1'b1);
      for (int k = 0; k < 3; k++) st("R10 hysteresis keeps lockout", 2'b00, 2'b00, 1'b1);
      rel_ok = 1'b1;
      st("R10 release edge still held", 2'b00, 2'b00, 1'b1);
      for (int k = 0; k < DEAD; k++) st("R10 restart dead time", 2'b00, 2'b00, 1'b1);
      st("R10 restart reaches high sides", 2'b11, 2'b00, 1'b1);
      // overcurrent fault
      f_oc = 1'b1;
      st("R7 overcurrent trips", 2'b00, 2'b00, 1'b0);
      f_oc = 1'b0;
      for (int k = 0; k < 3; k++) st("R8 fault stays latched", 2'b00, 2'b00, 1'b0);
      trip_ok = 1'b0; rel_ok = 1'b0;
      st("R8 latched through trip edge", 2'b00, 2'b00, 1'b0);
      trip_ok = 1'b1; rel_ok = 1'b1;
      st("R8 lockout clears latch", 2'b00, 2'b00, 1'b1);
      for (int k = 0; k < DEAD; k++) st("R8 restart dead time", 2'b00, 2'b00, 1'b1);
      st("R8 drive resumes", 2'b11, 2'b00, 1'b1);
      // overtemperature, cleared by power-on reset
      f_ot = 1'b1;
      st("R7 overtemperature trips", 2'b00, 2'b00, 1'b0);
      f_ot = 1'b0; dir = 2'b11; en = 1'b0; por_n = 1'b0;
      st("R11 power-on reset clears latch", 2'b00, 2'b00, 1'b1);
      por_n = 1'b1;
      st("R11 hold edge after reset", 2'b00, 2'b00, 1'b1);
      st("R2 settled low-side leg, enable low", 2'b00, 2'b00, 1'b1);
      // short flag blanking
      en = 1'b1;
      st("R4 brake again", 2'b00, 2'b11, 1'b1);
      f_sc = 1'b1;
      st("R9 short ignored inside blanking", 2'b00, 2'b11, 1'b1);
      f_sc = 1'b0;
      for (int k = 0; k < 12; k++) st("R9 stable drive", 2'b00, 2'b11, 1'b1);
      f_sc = 1'b1;
      st("R9 short accepted after blanking", 2'b00, 2'b00, 1'b0);
      f_sc = 1'b0;
      st("R8 short fault sticky", 2'b00, 2'b00, 1'b0);
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule